// File: doc/BRIEF.md
# Erase and Program Sequencer for a High-Voltage Byte-Wide Memory

This controller sits on the host side of an electrically erasable byte-wide memory. It drives the memory's control pins through the full timed sequence for two jobs. The first is a whole-chip erase followed by a blank check. The second is programming a run of bytes, each followed by its own read-back verify. The actual high-voltage switching sits outside the block. The controller only emits a two-bit level code for the output-enable/program pin and a flag that asks the driver to raise A9 to its erase level. Every phase length is a clock-cycle parameter.

A job starts with a single-cycle `start_i`, together with the job type, a base address and a byte count. For a programming job, bytes arrive on a valid/ready stream, one per programmed location. Each byte is set up, pulsed under program voltage, held, released, and read back with chip enable held low. After an erase pulse the whole array is read in ascending order and each byte must be 0xFF. The first mismatch ends the job and reports the failing address and the byte that was read back.

Top module: `burn_seq`

## Requirements
- R1: After reset: `busy_o`, `done_o`, `fail_o`, `mem_dq_oe_o`, `a9_hv_o` and `wr_ready_o` are 0, `mem_ce_n_o` is 1 and `oe_lvl_o` is 1 (the inactive level). Level codes are 0 = read-enable low, 1 = inactive high, 2 = program voltage, 3 = erase voltage.
- R2: Before each pulse, address and data are driven for exactly T_SET cycles with `oe_lvl_o` at 1. Then the high-voltage level is driven for exactly T_SET cycles with `mem_ce_n_o` still high.
- R3: A program pulse holds `mem_ce_n_o` low for exactly T_PGM cycles at level 2. An erase pulse holds it low for exactly T_ERS cycles at level 3. Each programmed byte gets exactly one pulse, and an erase job gets exactly one pulse.
- R4: From setup through hold of an erase, the address is all zeros, the data bus drives 0xFF and `a9_hv_o` is 1.
- R5: After `mem_ce_n_o` rises, data and address stay driven under high voltage for T_HOLD cycles. The high-voltage level then stays for another T_HOLD cycles with data released. The level then returns to 1 for T_REC cycles before any verify read.
- R6: A verify read holds `mem_ce_n_o` low and `oe_lvl_o` at 0 for T_ACC cycles per address, without toggling chip enable. The byte on `mem_dq_i` in the last of those cycles is compared with the expected value.
- R7: After an erase pulse, every address from 0 to 2^AW-1 is read once in ascending order and compared with 0xFF.
- R8: A verify mismatch ends the job. `fail_o` goes to 1 in the `done_o` cycle, `fail_addr_o` holds the address and `fail_data_o` holds the byte read back. Nothing further is pulsed.
- R9: `busy_o` is high from the cycle after an accepted start through the single `done_o` cycle. `start_i` while busy has no effect.
- R10: `wr_ready_o` is high only while waiting for the next program byte. Each accepted byte goes to the next address from `base_i`, wrapping modulo 2^AW. A count of 0 completes at once with no pulse and no failure.
- R11: `fail_o` is cleared when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a job (sampled while idle) |
| erase_i | input | 1 | Job type: 1 erase plus blank check, 0 program |
| base_i | input | AW | First address of a program job |
| count_i | input | AW+1 | Number of bytes to program |
| wr_data_i | input | 8 | Program byte stream data |
| wr_valid_i | input | 1 | Program byte stream valid |
| wr_ready_o | output | 1 | Controller waits for a byte |
| mem_addr_o | output | AW | Memory address |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 8 | Data read from the memory |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| oe_lvl_o | output | 2 | Level code for the output-enable/program pin |
| a9_hv_o | output | 1 | Request erase level on A9 |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle job completion |
| fail_o | output | 1 | Last job failed verify |
| fail_addr_o | output | AW | Address of the failing byte |
| fail_data_o | output | 8 | Byte read back at the failure |

## Verification
The assertions assume that `start_i`, `erase_i`, `base_i`, `count_i` and the byte stream are synchronous to `clk`. They also assume that `mem_dq_i` is steady during each read window. The bench meets this by changing every input only at the falling edge. It offers a byte only while `wr_ready_o` is seen high, and it models the memory as a plain array that is read combinationally and written when chip enable rises under high voltage. The bench pokes a stray start mid-job to check that such a start is ignored. It also injects faulty cells, which produce the mismatch path in both program and erase jobs.

// File: rtl/burn_pkg.sv
package burn_pkg;

  typedef enum logic [1:0] {
    LV_READ  = 2'd0,
    LV_IDLE  = 2'd1,
    LV_PROG  = 2'd2,
    LV_ERASE = 2'd3
  } lvl_t;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_SETUP, S_HVON, S_PULSE,
    S_HOLD, S_OEH, S_RECOV, S_VFY, S_DONE
  } st_t;

  function automatic lvl_t hv_level(input logic ers);
    return ers ? LV_ERASE : LV_PROG;
  endfunction

  function automatic logic [7:0] expect_byte(input logic ers, input logic [7:0] want);
    return ers ? 8'hFF : want;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/burn_timer.sv
module burn_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/burn_cursor.sv
module burn_cursor #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [AW:0]   count,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          last
);
  logic [AW:0] rem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      rem  <= '0;
    end else if (load) begin
      addr <= base;
      rem  <= count;
    end else if (step) begin
      addr <= addr + 1'b1;
      rem  <= rem - 1'b1;
    end
  end

  assign last = (rem == {{AW{1'b0}}, 1'b1});
endmodule

// File: rtl/burn_seq.sv
module burn_seq
  import burn_pkg::*;
#(
  parameter int AW     = 16,
  parameter int T_SET  = 100,
  parameter int T_PGM  = 5000,
  parameter int T_ERS  = 5000000,
  parameter int T_HOLD = 100,
  parameter int T_REC  = 100,
  parameter int T_ACC  = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          erase_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW:0]   count_i,
  input  logic [7:0]    wr_data_i,
  input  logic          wr_valid_i,
  output logic          wr_ready_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [7:0]    mem_dq_i,
  output logic          mem_ce_n_o,
  output logic [1:0]    oe_lvl_o,
  output logic          a9_hv_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o,
  output logic [7:0]    fail_data_o
);
  localparam int T_MAX = max_of(max_of(max_of(T_SET, T_PGM), max_of(T_ERS, T_HOLD)),
                                max_of(T_REC, T_ACC));
  localparam int TW = $clog2(T_MAX + 1);
  localparam logic [AW:0] FULL = {1'b1, {AW{1'b0}}};

  function automatic int phase_len(input st_t s, input logic ers);
    case (s)
      S_SETUP, S_HVON: return T_SET;
      S_PULSE:         return ers ? T_ERS : T_PGM;
      S_HOLD, S_OEH:   return T_HOLD;
      S_RECOV:         return T_REC;
      S_VFY:           return T_ACC;
      default:         return 1;
    endcase
  endfunction

  st_t           state_q, state_n;
  logic          mode_q;
  logic [7:0]    dreg;
  logic          fail_q;
  logic [AW-1:0] fail_addr_q;
  logic [7:0]    fail_data_q;

  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic [AW-1:0] cur_addr;
  logic          cur_last, cur_step;

  // named internal events
  logic accept, take, vfy_end, vfy_ok, mismatch, vfy_rd, hv_on;
  lvl_t lvl;
  logic ce_n, drive, a9;

  assign accept   = (state_q == S_IDLE) && start_i;
  assign take     = (state_q == S_FETCH) && wr_valid_i;
  assign vfy_rd   = (state_q == S_VFY);
  assign vfy_end  = vfy_rd && tmr_done;
  assign vfy_ok   = (mem_dq_i == expect_byte(mode_q, dreg));
  assign mismatch = vfy_end && !vfy_ok;
  assign cur_step = vfy_end && vfy_ok && !cur_last;

  burn_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
  );

  burn_cursor #(.AW(AW)) u_cursor (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .base(erase_i ? {AW{1'b0}} : base_i),
    .count(erase_i ? FULL : count_i),
    .step(cur_step), .addr(cur_addr), .last(cur_last)
  );

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      S_IDLE:  if (start_i) state_n = erase_i ? S_SETUP
                                    : ((count_i == '0) ? S_DONE : S_FETCH);
      S_FETCH: if (wr_valid_i) state_n = S_SETUP;
      S_SETUP: if (tmr_done) state_n = S_HVON;
      S_HVON:  if (tmr_done) state_n = S_PULSE;
      S_PULSE: if (tmr_done) state_n = S_HOLD;
      S_HOLD:  if (tmr_done) state_n = S_OEH;
      S_OEH:   if (tmr_done) state_n = S_RECOV;
      S_RECOV: if (tmr_done) state_n = S_VFY;
      S_VFY: begin
        if (tmr_done) begin
          if (!vfy_ok || cur_last) state_n = S_DONE;
          else if (!mode_q)        state_n = S_FETCH;
        end
      end
      S_DONE:  state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  assign tmr_load = (state_n != state_q) || (vfy_end && state_n == S_VFY);
  assign tmr_val  = TW'(phase_len(state_n, mode_q) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      mode_q      <= 1'b0;
      dreg        <= '0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
      fail_data_q <= '0;
    end else begin
      state_q <= state_n;
      if (accept) begin
        mode_q <= erase_i;
        fail_q <= 1'b0;
      end
      if (take) dreg <= wr_data_i;
      if (mismatch) begin
        fail_q      <= 1'b1;
        fail_addr_q <= cur_addr;
        fail_data_q <= mem_dq_i;
      end
    end
  end

  always_comb begin
    ce_n  = 1'b1;
    lvl   = LV_IDLE;
    drive = 1'b0;
    a9    = 1'b0;
    unique case (state_q)
      S_SETUP: begin drive = 1'b1; a9 = mode_q; end
      S_HVON, S_HOLD: begin drive = 1'b1; a9 = mode_q; lvl = hv_level(mode_q); end
      S_PULSE: begin drive = 1'b1; a9 = mode_q; lvl = hv_level(mode_q); ce_n = 1'b0; end
      S_OEH:   lvl = hv_level(mode_q);
      S_VFY:   begin ce_n = 1'b0; lvl = LV_READ; end
      default: ;
    endcase
  end

  assign hv_on       = lvl[1];
  assign mem_ce_n_o  = ce_n;
  assign oe_lvl_o    = lvl;
  assign mem_dq_oe_o = drive;
  assign a9_hv_o     = a9;
  assign mem_addr_o  = cur_addr;
  assign mem_dq_o    = expect_byte(mode_q, dreg);
  assign wr_ready_o  = (state_q == S_FETCH);
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign fail_o      = fail_q;
  assign fail_addr_o = fail_addr_q;
  assign fail_data_o = fail_data_q;
endmodule

// File: rtl/burn_seq_chk.sv
module burn_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          wr_ready_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [7:0]    mem_dq_o,
  input logic          mem_dq_oe_o,
  input logic          mem_ce_n_o,
  input logic [1:0]    oe_lvl_o,
  input logic          a9_hv_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          fail_o,
  input logic          vfy_rd,
  input logic          hv
);
  a_r2_hv_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hv) |-> ($past(mem_dq_oe_o) && $past(oe_lvl_o) == 2'd1 && mem_ce_n_o));

  a_r3_pulse_under_hv: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ce_n_o) && hv) |-> $past(hv));

  a_r4_erase_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n_o && oe_lvl_o == 2'd3) |->
      (mem_addr_o == '0 && mem_dq_o == 8'hFF && mem_dq_oe_o && a9_hv_o));

  a_r5_hold_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_ce_n_o) && hv) |->
      (mem_dq_oe_o && $stable(mem_addr_o) && $stable(mem_dq_o)));

  a_r6_ce_steady_in_verify: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_rd && $past(vfy_rd)) |-> (!mem_ce_n_o && $stable(mem_ce_n_o)));

  a_r8_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> done_o);

  a_r9_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> busy_o);

  a_r10_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready_o |-> (!hv && mem_ce_n_o && !mem_dq_oe_o));
endmodule

bind burn_seq burn_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_ready_o(wr_ready_o),
  .mem_addr_o(mem_addr_o), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
  .mem_ce_n_o(mem_ce_n_o), .oe_lvl_o(oe_lvl_o), .a9_hv_o(a9_hv_o),
  .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
  .vfy_rd(vfy_rd), .hv(hv_on)
);

// File: tb/burn_seq_tb.sv
module burn_seq_tb;
  localparam int CLK_NS = 10;
  localparam int AW = 4;
  localparam int NB = 1 << AW;
  localparam int T_SET = 2, T_PGM = 5, T_ERS = 9, T_HOLD = 3, T_REC = 4, T_ACC = 2;

  typedef struct packed {
    logic       ers;
    logic [3:0] base;
    logic [4:0] cnt;
    logic [7:0] seed;
    logic       fen;
    logic [3:0] faddr;
    logic [7:0] fmask;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 4'd3,  5'd5,  8'hA5, 1'b0, 4'd0, 8'h00},
    '{1'b0, 4'd14, 5'd4,  8'h3C, 1'b0, 4'd0, 8'h00},
    '{1'b1, 4'd0,  5'd0,  8'h00, 1'b0, 4'd0, 8'h00},
    '{1'b0, 4'd0,  5'd16, 8'h00, 1'b0, 4'd0, 8'h00},
    '{1'b0, 4'd5,  5'd6,  8'h10, 1'b1, 4'd7, 8'h01},
    '{1'b1, 4'd0,  5'd0,  8'h00, 1'b1, 4'd9, 8'h10},
    '{1'b0, 4'd8,  5'd0,  8'h77, 1'b0, 4'd0, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, erase_i = 1'b0, wr_valid_i = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic [AW:0] count_i = '0;
  logic [7:0] wr_data_i = '0;
  logic wr_ready_o, mem_dq_oe_o, mem_ce_n_o, a9_hv_o, busy_o, done_o, fail_o;
  logic [AW-1:0] mem_addr_o, fail_addr_o;
  logic [7:0] mem_dq_o, mem_dq_i, fail_data_o;
  logic [1:0] oe_lvl_o;

  always #(CLK_NS/2) clk = ~clk;

  burn_seq #(.AW(AW), .T_SET(T_SET), .T_PGM(T_PGM), .T_ERS(T_ERS),
             .T_HOLD(T_HOLD), .T_REC(T_REC), .T_ACC(T_ACC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .erase_i(erase_i),
    .base_i(base_i), .count_i(count_i), .wr_data_i(wr_data_i),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .mem_addr_o(mem_addr_o),
    .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o), .mem_dq_i(mem_dq_i),
    .mem_ce_n_o(mem_ce_n_o), .oe_lvl_o(oe_lvl_o), .a9_hv_o(a9_hv_o),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
    .fail_addr_o(fail_addr_o), .fail_data_o(fail_data_o)
  );

  // memory model and pin monitor
  logic [7:0] arr [NB];
  logic case_init = 1'b0, pre_ers = 1'b0, fen = 1'b0;
  logic [3:0] faddr = '0;
  logic [7:0] fmask = '0;
  int n_pp, n_ep, n_rd, ers_bad;
  int su_len, hvpre_len, pulse_len, hold_len, oeh_len, rec_len, vr_len;
  int run_su, run_a, run_p, run_o, run_r, run_v;
  logic p_ce, p_hv, p_dqoe, p_rd, p_a9;
  logic [1:0] p_oe;
  logic [3:0] p_addr;
  logic [7:0] p_dq;

  assign mem_dq_i = (!mem_ce_n_o && oe_lvl_o == 2'd0) ? arr[mem_addr_o] : 8'h00;

  always @(negedge clk) begin
    if (case_init) begin
      for (int i = 0; i < NB; i++) arr[i] = pre_ers ? 8'(i * 7 + 1) : 8'hFF;
      n_pp = 0; n_ep = 0; n_rd = 0; ers_bad = 0;
      su_len = -1; hvpre_len = -1; pulse_len = -1; hold_len = -1;
      oeh_len = -1; rec_len = -1; vr_len = -1;
      run_su = 0; run_a = 0; run_p = 0; run_o = 0; run_r = 0; run_v = 0;
      p_ce = 1'b1; p_hv = 1'b0; p_dqoe = 1'b0; p_rd = 1'b0; p_a9 = 1'b0;
      p_oe = 2'd1; p_addr = '0; p_dq = '0;
    end else if (rst_n) begin
      automatic logic hv = oe_lvl_o[1];
      automatic logic rd = !mem_ce_n_o && oe_lvl_o == 2'd0;
      if (mem_ce_n_o && !p_ce && p_hv) begin
        pulse_len = run_p;
        if (p_oe == 2'd2) begin
          arr[p_addr] = arr[p_addr] & (p_dq | ((fen && p_addr == faddr) ? fmask : 8'h00));
          n_pp++;
        end else if (p_a9) begin
          for (int i = 0; i < NB; i++) arr[i] = 8'hFF;
          if (fen) arr[faddr] = 8'hFF & ~fmask;
          n_ep++;
        end
      end
      run_p = (!mem_ce_n_o && hv) ? run_p + 1 : 0;
      if (hv && !p_hv) su_len = run_su;
      run_su = (mem_dq_oe_o && oe_lvl_o == 2'd1 && mem_ce_n_o) ? run_su + 1 : 0;
      if (!mem_ce_n_o && p_ce && hv) hvpre_len = run_a;
      if (!mem_dq_oe_o && p_dqoe && hv) hold_len = run_a;
      run_a = (hv && mem_ce_n_o && mem_dq_oe_o) ? run_a + 1 : 0;
      if (!hv && p_hv) oeh_len = run_o;
      run_o = (hv && mem_ce_n_o && !mem_dq_oe_o) ? run_o + 1 : 0;
      if (rd && !p_rd) rec_len = run_r;
      run_r = (oe_lvl_o == 2'd1 && mem_ce_n_o && !mem_dq_oe_o) ? run_r + 1 : 0;
      if (rd && (!p_rd || mem_addr_o != p_addr)) n_rd++;
      if (p_rd && (!rd || mem_addr_o != p_addr)) vr_len = run_v;
      run_v = rd ? ((p_rd && mem_addr_o == p_addr) ? run_v + 1 : 1) : 0;
      if (!mem_ce_n_o && oe_lvl_o == 2'd3 &&
          !(mem_addr_o == '0 && mem_dq_o == 8'hFF && mem_dq_oe_o && a9_hv_o)) ers_bad++;
      p_ce = mem_ce_n_o; p_hv = hv; p_dqoe = mem_dq_oe_o; p_rd = rd; p_a9 = a9_hv_o;
      p_oe = oe_lvl_o; p_addr = mem_addr_o; p_dq = mem_dq_o;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dat(input logic [7:0] s, input int k);
    return s + 8'(k * 29);
  endfunction

  task automatic run_case(input vec_t v, input bit poke);
    logic [7:0] exp_mem [NB];
    int exp_np = 0, exp_rd = 0, fa = 0, fd = 0, k = 0, cyc = 0, bad = 0;
    bit exp_fail = 1'b0, got_done;
    // expected results from the requirements
    if (v.ers) begin
      for (int i = 0; i < NB; i++) exp_mem[i] = 8'hFF;
      if (v.fen) exp_mem[v.faddr] = 8'hFF & ~v.fmask;
      exp_fail = v.fen && v.fmask != 8'h00;
      fa = v.faddr; fd = 8'hFF & ~v.fmask;
      exp_rd = exp_fail ? v.faddr + 1 : NB;
    end else begin
      for (int i = 0; i < NB; i++) exp_mem[i] = 8'hFF;
      for (int j = 0; j < v.cnt && !exp_fail; j++) begin
        automatic int a = (v.base + j) % NB;
        automatic logic [7:0] d = dat(v.seed, j);
        automatic logic [7:0] st = d | ((v.fen && a == v.faddr) ? v.fmask : 8'h00);
        exp_mem[a] = st;
        exp_np++;
        if (st != d) begin exp_fail = 1'b1; fa = a; fd = st; end
      end
      exp_rd = exp_np;
    end
    fen = v.fen; faddr = v.faddr; fmask = v.fmask; pre_ers = v.ers;
    @(posedge clk); case_init = 1'b1;
    @(posedge clk); case_init = 1'b0;
    @(negedge clk);
    erase_i = v.ers; base_i = v.base; count_i = v.cnt; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R9 busy after start", busy_o, 1);
    chk("R11 fail cleared on start", fail_o, 0);
    got_done = done_o;
    while (!got_done && cyc < 20000) begin
      @(negedge clk); cyc++;
      wr_valid_i = 1'b0; start_i = 1'b0;
      if (poke && cyc == 5) begin start_i = 1'b1; erase_i = 1'b1; end
      if (done_o) got_done = 1'b1;
      else if (wr_ready_o) begin
        wr_valid_i = 1'b1; wr_data_i = dat(v.seed, k); k++;
      end
    end
    chk("R9 job reaches done", got_done, 1);
    chk("R8 fail flag", fail_o, exp_fail);
    if (exp_fail) begin
      chk("R8 fail address", fail_addr_o, fa);
      chk("R8 fail data", fail_data_o, fd);
    end
    for (int i = 0; i < NB; i++) if (arr[i] != exp_mem[i]) bad++;
    chk("R10 memory contents", bad, 0);
    chk("R3 program pulse count", n_pp, exp_np);
    chk("R3 erase pulse count", n_ep, v.ers ? 1 : 0);
    if (!v.ers) chk("R10 bytes consumed", k, exp_np);
    chk(v.ers ? "R7 verify read count" : "R6 verify read count", n_rd, exp_rd);
    if (n_pp + n_ep > 0) begin
      chk("R2 data setup cycles", su_len, T_SET);
      chk("R2 high voltage setup cycles", hvpre_len, T_SET);
      chk("R3 pulse width", pulse_len, v.ers ? T_ERS : T_PGM);
      chk("R5 data hold cycles", hold_len, T_HOLD);
      chk("R5 voltage hold cycles", oeh_len, T_HOLD);
      chk("R5 recovery cycles", rec_len, T_REC);
      chk("R6 read window cycles", vr_len, T_ACC);
    end
    if (v.ers) chk("R4 erase pin state", ers_bad, 0);
    @(negedge clk);
    chk("R9 done is one cycle", {done_o, busy_o}, 0);
    erase_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", busy_o, 0);
    chk("R1 ce_n at reset", mem_ce_n_o, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle outputs", {done_o, fail_o, mem_dq_oe_o, a9_hv_o, wr_ready_o}, 0);
    chk("R1 level code inactive", oe_lvl_o, 1);
    for (int i = 0; i < 7; i++) run_case(VECS[i], 1'b0);
    // stray start while busy must not turn the program job into an erase
    run_case(VECS[0], 1'b1);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog act=%0d exp=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule